// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

This block joins two independently clocked ports, A and B, with two separate first-in first-out buffers. One buffer carries 36-bit words from A to B and the other carries words from B to A. Each port has a chip select, a direction select, a mailbox select and an enable. Together these decide, on each rising edge of that port's own clock, whether the port writes one buffer, reads the other, or does nothing. Read data is registered: a word taken on a read edge appears on the port's data output just after that edge and stays there until the next accepted read.

Read and write pointers are one bit wider than the address and are held in Gray code. They reach the opposite clock domain through two-flop synchronizers. Port A has two threshold flags, both running on port A's clock. The near-full flag watches the A-to-B buffer and the near-empty flag watches the B-to-A buffer. Their offsets are static parameters. A change caused by port A's own edge shows on the flags right after that edge. A change caused by port B reaches them after the synchronizer delay, which is two or three CLKA edges depending on how the two clocks line up.

Top module: `bidir_cdc_fifo`

## Requirements
- R1: A port acts on a rising edge of its clock only when its enable is 1, its chip select is 0 and its mailbox select is 0. Any other combination stores no word, moves no pointer and leaves that port's data output unchanged.
- R2: On port A, direction 1 writes the A-to-B buffer. On port B, direction 1 reads it. Words leave in the order they entered, also when writes and reads happen at the same time, and each word shows on dout_b right after the read edge.
- R3: On port B, direction 0 writes the B-to-A buffer. On port A, direction 0 reads it. Words leave in write order on dout_a.
- R4: A write to a buffer that is full, as seen by the writing port, is dropped. The word-count view at the writer never exceeds DEPTH = 2^ADDR_W, and later reads return only the first DEPTH words, unchanged.
- R5: A read from a buffer that is empty, as seen by the reading port, is ignored. The read port's data output holds its previous value and no pointer moves.
- R6: a_afull_n is 0 while port A sees DEPTH-AF_OFS or more words in the A-to-B buffer, and 1 while it sees DEPTH-AF_OFS-1 or fewer. It is valid right after the CLKA edge of a port-A write.
- R7: a_aempty_n is 0 while port A sees AE_OFS or fewer words in the B-to-A buffer, and 1 once it sees AE_OFS+1 or more. It is valid right after the CLKA edge of a port-A read.
- R8: A count change caused by a port-B edge reaches a_afull_n and a_aempty_n no later than the third rising CLKA edge after that port-B edge.
- R9: Each Gray-coded write pointer changes in at most one bit per edge of its own clock.
- R10: After reset, both buffers are empty, dout_a and dout_b are 0, a_afull_n is 1 and a_aempty_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| rst_n | input | 1 | Asynchronous reset of both domains, active low |
| cs_a_n | input | 1 | Port A chip select, active low |
| dir_a | input | 1 | Port A direction: 1 writes A-to-B, 0 reads B-to-A |
| mbox_a | input | 1 | Port A mailbox select; 1 blocks buffer access |
| en_a | input | 1 | Port A enable |
| din_a | input | 36 | Port A write data |
| dout_a | output | 36 | Port A registered read data (B-to-A buffer) |
| a_afull_n | output | 1 | Near-full of A-to-B buffer, on clk_a, active low |
| a_aempty_n | output | 1 | Near-empty of B-to-A buffer, on clk_a, active low |
| cs_b_n | input | 1 | Port B chip select, active low |
| dir_b | input | 1 | Port B direction: 1 reads A-to-B, 0 writes B-to-A |
| mbox_b | input | 1 | Port B mailbox select; 1 blocks buffer access |
| en_b | input | 1 | Port B enable |
| din_b | input | 36 | Port B write data |
| dout_b | output | 36 | Port B registered read data (A-to-B buffer) |

## Verification
The case that matters is one buffer being written at port A and read at port B in overlapping cycles of unrelated clocks, so that both pointers move while each is crossing into the other domain. The bench runs the two ports in parallel threads. It keeps the model count away from full and empty by margins larger than the synchronizer lag, so that every request it issues must be accepted. Each word read out is judged against a queue model. The flags are judged against thresholds the bench computes from its own queue sizes, either right after a port-A edge or three CLKA edges after a port-B edge.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;

  localparam int WORD_W = 36;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } port_op_e;

  // Turns one port's strobes into an operation; wr_dir is the direction
  // value that means "write" on this port.
  function automatic port_op_e decode_op(input logic cs_n, input logic dir,
                                         input logic mbox, input logic en,
                                         input logic wr_dir);
    if (!en || cs_n || mbox) return OP_IDLE;
    return (dir == wr_dir) ? OP_WRITE : OP_READ;
  endfunction

endpackage

// File: rtl/cdc_sync2.sv
module cdc_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/port_sel.sv
module port_sel
  import bfifo_pkg::*;
#(
  parameter bit WR_ON_DIR = 1'b1
) (
  input  logic cs_n,
  input  logic dir,
  input  logic mbox,
  input  logic en,
  output logic wr_req,
  output logic rd_req
);
  port_op_e op;

  assign op     = decode_op(cs_n, dir, mbox, en, WR_ON_DIR);
  assign wr_req = (op == OP_WRITE);
  assign rd_req = (op == OP_READ);
endmodule

// File: rtl/fifo_core.sv
module fifo_core #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic [AW:0]   wr_level,
  output logic [AW:0]   rd_level,
  output logic [AW:0]   wgray
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, rbin, rgray, rgray_w, wgray_r;
  logic [PW-1:0] wbin_nxt, rbin_nxt;
  logic          wr_fire, rd_fire;

  // write side
  assign full     = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
  assign wr_fire  = wr_req && !full;
  assign wbin_nxt = wbin + PW'(1);
  assign wr_level = wbin - g2b(rgray_w);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wbin_nxt;
      wgray <= b2g(wbin_nxt);
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[wbin[AW-1:0]] <= wr_data;
  end

  // read side
  assign empty    = (rgray == wgray_r);
  assign rd_fire  = rd_req && !empty;
  assign rbin_nxt = rbin + PW'(1);
  assign rd_level = g2b(wgray_r) - rbin;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rd_data <= '0;
    end else if (rd_fire) begin
      rbin    <= rbin_nxt;
      rgray   <= b2g(rbin_nxt);
      rd_data <= mem[rbin[AW-1:0]];
    end
  end

  cdc_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w));
  cdc_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));
endmodule

// File: rtl/a_flags.sv
module a_flags #(
  parameter int PW     = 5,
  parameter int DEPTH  = 16,
  parameter int AE_OFS = 2,
  parameter int AF_OFS = 2
) (
  input  logic [PW-1:0] out_level,
  input  logic [PW-1:0] in_level,
  output logic          afull_n,
  output logic          aempty_n
);
  function automatic logic near_full(input logic [PW-1:0] lvl);
    return lvl >= PW'(DEPTH - AF_OFS);
  endfunction

  function automatic logic above_low(input logic [PW-1:0] lvl);
    return lvl > PW'(AE_OFS);
  endfunction

  assign afull_n  = !near_full(out_level);
  assign aempty_n = above_low(in_level);
endmodule

// File: rtl/bidir_cdc_fifo.sv
module bidir_cdc_fifo
  import bfifo_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int AE_OFS = 8,
  parameter int AF_OFS = 8
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              cs_a_n,
  input  logic              dir_a,
  input  logic              mbox_a,
  input  logic              en_a,
  input  logic [WORD_W-1:0] din_a,
  output logic [WORD_W-1:0] dout_a,
  output logic              a_afull_n,
  output logic              a_aempty_n,
  input  logic              cs_b_n,
  input  logic              dir_b,
  input  logic              mbox_b,
  input  logic              en_b,
  input  logic [WORD_W-1:0] din_b,
  output logic [WORD_W-1:0] dout_b
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  // named internal events, observed by the bound checker
  logic          ab_wr_req, ab_rd_req, ba_wr_req, ba_rd_req;
  logic          ab_full, ab_empty, ba_full, ba_empty;
  logic [PW-1:0] ab_wr_level, ab_rd_level, ba_wr_level, ba_rd_level;
  logic [PW-1:0] ab_wgray, ba_wgray;

  port_sel #(.WR_ON_DIR(1'b1)) u_sel_a (
    .cs_n(cs_a_n), .dir(dir_a), .mbox(mbox_a), .en(en_a),
    .wr_req(ab_wr_req), .rd_req(ba_rd_req)
  );

  port_sel #(.WR_ON_DIR(1'b0)) u_sel_b (
    .cs_n(cs_b_n), .dir(dir_b), .mbox(mbox_b), .en(en_b),
    .wr_req(ba_wr_req), .rd_req(ab_rd_req)
  );

  fifo_core #(.DW(WORD_W), .AW(ADDR_W)) u_ab (
    .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
    .wr_req(ab_wr_req), .wr_data(din_a),
    .rd_req(ab_rd_req), .rd_data(dout_b),
    .full(ab_full), .empty(ab_empty),
    .wr_level(ab_wr_level), .rd_level(ab_rd_level), .wgray(ab_wgray)
  );

  fifo_core #(.DW(WORD_W), .AW(ADDR_W)) u_ba (
    .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
    .wr_req(ba_wr_req), .wr_data(din_b),
    .rd_req(ba_rd_req), .rd_data(dout_a),
    .full(ba_full), .empty(ba_empty),
    .wr_level(ba_wr_level), .rd_level(ba_rd_level), .wgray(ba_wgray)
  );

  a_flags #(.PW(PW), .DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) u_flags (
    .out_level(ab_wr_level), .in_level(ba_rd_level),
    .afull_n(a_afull_n), .aempty_n(a_aempty_n)
  );
endmodule

// File: rtl/bidir_cdc_fifo_chk.sv
module bidir_cdc_fifo_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk_a,
  input logic              clk_b,
  input logic              rst_n,
  input logic              cs_a_n,
  input logic              mbox_a,
  input logic              en_a,
  input logic [35:0]       dout_a,
  input logic [35:0]       dout_b,
  input logic              a_afull_n,
  input logic              a_aempty_n,
  input logic              ab_wr_req,
  input logic              ab_rd_req,
  input logic              ba_wr_req,
  input logic              ba_rd_req,
  input logic              ab_full,
  input logic              ab_empty,
  input logic              ba_full,
  input logic              ba_empty,
  input logic [ADDR_W:0]   ab_wr_level,
  input logic [ADDR_W:0]   ab_rd_level,
  input logic [ADDR_W:0]   ba_wr_level,
  input logic [ADDR_W:0]   ba_rd_level,
  input logic [ADDR_W:0]   ab_wgray,
  input logic [ADDR_W:0]   ba_wgray
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

  assert_idle_hold_R1: assert property (@(posedge clk_a) disable iff (!rst_n)
    !(en_a && !cs_a_n && !mbox_a) |=> $stable(dout_a));

  assert_no_overflow_R4: assert property (@(posedge clk_a) disable iff (!rst_n)
    ab_wr_level <= DEPTH_P);

  assert_no_overflow_b_R4: assert property (@(posedge clk_b) disable iff (!rst_n)
    (ba_wr_level <= DEPTH_P) && (ab_rd_level <= DEPTH_P));

  assert_full_write_R4: assert property (@(posedge clk_a) disable iff (!rst_n)
    (ab_full && ab_wr_req) |=> (ab_wr_level <= $past(ab_wr_level)));

  assert_full_write_b_R4: assert property (@(posedge clk_b) disable iff (!rst_n)
    (ba_full && ba_wr_req) |=> (ba_wr_level <= $past(ba_wr_level)));

  assert_empty_read_R5: assert property (@(posedge clk_a) disable iff (!rst_n)
    (ba_empty && ba_rd_req) |=> $stable(dout_a));

  assert_empty_read_b_R5: assert property (@(posedge clk_b) disable iff (!rst_n)
    (ab_empty && ab_rd_req) |=> $stable(dout_b));

  assert_full_flag_R6: assert property (@(posedge clk_a) disable iff (!rst_n)
    ab_full |-> !a_afull_n);

  assert_empty_flag_R7: assert property (@(posedge clk_a) disable iff (!rst_n)
    (ba_empty || (ba_rd_level == '0)) |-> !a_aempty_n);

  assert_gray_step_a_R9: assert property (@(posedge clk_a) disable iff (!rst_n)
    $onehot0(ab_wgray ^ $past(ab_wgray)));

  assert_gray_step_b_R9: assert property (@(posedge clk_b) disable iff (!rst_n)
    $onehot0(ba_wgray ^ $past(ba_wgray)));
endmodule

bind bidir_cdc_fifo bidir_cdc_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
  .cs_a_n(cs_a_n), .mbox_a(mbox_a), .en_a(en_a),
  .dout_a(dout_a), .dout_b(dout_b),
  .a_afull_n(a_afull_n), .a_aempty_n(a_aempty_n),
  .ab_wr_req(ab_wr_req), .ab_rd_req(ab_rd_req),
  .ba_wr_req(ba_wr_req), .ba_rd_req(ba_rd_req),
  .ab_full(ab_full), .ab_empty(ab_empty),
  .ba_full(ba_full), .ba_empty(ba_empty),
  .ab_wr_level(ab_wr_level), .ab_rd_level(ab_rd_level),
  .ba_wr_level(ba_wr_level), .ba_rd_level(ba_rd_level),
  .ab_wgray(ab_wgray), .ba_wgray(ba_wgray)
);

// File: tb/bidir_cdc_fifo_tb.sv
`timescale 1ns/1ps
module bidir_cdc_fifo_tb;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;
  localparam int X2    = 3;
  localparam int Y1    = 4;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic cs_a_n = 1'b1, dir_a = 1'b0, mbox_a = 1'b0, en_a = 1'b0;
  logic cs_b_n = 1'b1, dir_b = 1'b0, mbox_b = 1'b0, en_b = 1'b0;
  logic [35:0] din_a = '0, din_b = '0;
  logic [35:0] dout_a, dout_b;
  logic a_afull_n, a_aempty_n;

  always #2.5 clk_a = ~clk_a;
  always #3.6 clk_b = ~clk_b;

  bidir_cdc_fifo #(.ADDR_W(AW), .AE_OFS(X2), .AF_OFS(Y1)) u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .cs_a_n(cs_a_n), .dir_a(dir_a), .mbox_a(mbox_a), .en_a(en_a),
    .din_a(din_a), .dout_a(dout_a),
    .a_afull_n(a_afull_n), .a_aempty_n(a_aempty_n),
    .cs_b_n(cs_b_n), .dir_b(dir_b), .mbox_b(mbox_b), .en_b(en_b),
    .din_b(din_b), .dout_b(dout_b)
  );

  int n_cmp = 0, n_bad = 0;
  logic [35:0] q_ab[$], q_ba[$];
  logic [35:0] exp_a = '0, exp_b = '0;

  function automatic logic [35:0] mkw(input int tag, input int i);
    return {tag[3:0], 32'(i * 32'd40503 + tag * 32'd977)};
  endfunction

  function automatic logic exp_afull_n();
    return !(q_ab.size() >= DEPTH - Y1);
  endfunction

  function automatic logic exp_aempty_n();
    return q_ba.size() > X2;
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    chk(req, {35'd0, a_afull_n}, {35'd0, exp_afull_n()});
    chk(req, {35'd0, a_aempty_n}, {35'd0, exp_aempty_n()});
  endtask

  // one port-A cycle; the model follows the pin decode, dout_a compared after
  task automatic a_cycle(input logic cs_n, input logic dir, input logic mb,
                         input logic en, input logic [35:0] d, input string req);
    @(negedge clk_a);
    cs_a_n = cs_n; dir_a = dir; mbox_a = mb; en_a = en; din_a = d;
    @(posedge clk_a);
    #1;
    en_a = 1'b0; cs_a_n = 1'b1; mbox_a = 1'b0;
    if (en && !cs_n && !mb) begin
      if (dir) begin
        if (q_ab.size() < DEPTH) q_ab.push_back(d);
      end else if (q_ba.size() > 0) begin
        exp_a = q_ba.pop_front();
      end
    end
    @(negedge clk_a);
    chk(req, dout_a, exp_a);
  endtask

  task automatic b_cycle(input logic cs_n, input logic dir, input logic mb,
                         input logic en, input logic [35:0] d, input string req);
    @(negedge clk_b);
    cs_b_n = cs_n; dir_b = dir; mbox_b = mb; en_b = en; din_b = d;
    @(posedge clk_b);
    #1;
    en_b = 1'b0; cs_b_n = 1'b1; mbox_b = 1'b0;
    if (en && !cs_n && !mb) begin
      if (!dir) begin
        if (q_ba.size() < DEPTH) q_ba.push_back(d);
      end else if (q_ab.size() > 0) begin
        exp_b = q_ab.pop_front();
      end
    end
    @(negedge clk_b);
    chk(req, dout_b, exp_b);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk_b);
    repeat (4) @(posedge clk_a);
  endtask

  task automatic wait_a3();
    repeat (3) @(posedge clk_a);
    @(negedge clk_a);
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int got;
    repeat (5) @(posedge clk_a);
    @(negedge clk_a);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10", dout_a, '0);
    chk("R10", dout_b, '0);
    chk_flags("R10");

    // R1: blocked strobes on port A store nothing
    a_cycle(1'b1, 1'b1, 1'b0, 1'b1, mkw(1, 1), "R1");
    a_cycle(1'b0, 1'b1, 1'b1, 1'b1, mkw(1, 2), "R1");
    a_cycle(1'b0, 1'b1, 1'b0, 1'b0, mkw(1, 3), "R1");
    settle();
    b_cycle(1'b0, 1'b1, 1'b0, 1'b1, '0, "R5");
    a_cycle(1'b0, 1'b1, 1'b0, 1'b1, mkw(1, 4), "R2");
    settle();
    b_cycle(1'b0, 1'b1, 1'b1, 1'b1, '0, "R1");   // mailbox read on B: hold
    b_cycle(1'b1, 1'b1, 1'b0, 1'b1, '0, "R1");   // deselected read on B: hold
    b_cycle(1'b0, 1'b1, 1'b0, 1'b1, '0, "R2");

    // R2: plain A-to-B transfer
    for (int i = 0; i < 10; i++) a_cycle(1'b0, 1'b1, 1'b0, 1'b1, mkw(2, i), "R2");
    settle();
    for (int i = 0; i < 10; i++) b_cycle(1'b0, 1'b1, 1'b0, 1'b1, '0, "R2");

    // R3/R7/R8: B-to-A transfer with near-empty tracking
    for (int i = 0; i < 8; i++) begin
      b_cycle(1'b0, 1'b0, 1'b0, 1'b1, mkw(3, i), "R3");
      wait_a3();
      chk("R8", {35'd0, a_aempty_n}, {35'd0, exp_aempty_n()});
    end
    a_cycle(1'b0, 1'b0, 1'b1, 1'b1, '0, "R1");   // mailbox read on A: hold
    for (int i = 0; i < 8; i++) begin
      a_cycle(1'b0, 1'b0, 1'b0, 1'b1, '0, "R3");
      chk("R7", {35'd0, a_aempty_n}, {35'd0, exp_aempty_n()});
    end

    // R4/R6: fill past full, near-full after each own write
    for (int i = 0; i < DEPTH + 3; i++) begin
      a_cycle(1'b0, 1'b1, 1'b0, 1'b1, mkw(4, i), "R4");
      chk("R6", {35'd0, a_afull_n}, {35'd0, exp_afull_n()});
    end
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      b_cycle(1'b0, 1'b1, 1'b0, 1'b1, '0, "R4");
      wait_a3();
      chk("R8", {35'd0, a_afull_n}, {35'd0, exp_afull_n()});
    end
    settle();
    // R5: reads from empty buffers hold the outputs
    b_cycle(1'b0, 1'b1, 1'b0, 1'b1, '0, "R5");
    a_cycle(1'b0, 1'b0, 1'b0, 1'b1, '0, "R5");

    // R2: simultaneous A writes and B reads on the same buffer
    got = 0;
    fork
      begin
        for (int i = 0; i < 60; ) begin
          if (q_ab.size() <= DEPTH - 8) begin
            a_cycle(1'b0, 1'b1, 1'b0, 1'b1, mkw(7, i), "R2");
            i++;
          end else begin
            @(posedge clk_a);
          end
        end
      end
      begin
        while (got < 52) begin
          if (q_ab.size() >= 8) begin
            b_cycle(1'b0, 1'b1, 1'b0, 1'b1, '0, "R2");
            got++;
          end else begin
            @(posedge clk_b);
          end
        end
      end
    join
    settle();
    while (q_ab.size() > 0) b_cycle(1'b0, 1'b1, 1'b0, 1'b1, '0, "R2");
    settle();
    @(negedge clk_a);
    chk_flags("R6");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule